// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block decides, cycle by cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) may proceed. It keeps its own shadow copy of the destination-register information for the instructions that are older than decode and still in flight. It compares that copy against the source registers that the decoding instruction actually reads. When a value cannot be delivered in time, it drops the program-counter enable and the fetch/decode register enable, so the front of the pipe holds. In the same cycle it asks the decode/execute register to load a no-op bundle, which puts a bubble behind the older instructions.

A parameter picks the policy. Without forwarding, the register file writes in the first half of a cycle and reads in the second half. A consumer therefore waits while its producer sits in execute or memory, which costs two cycles when it directly follows the producer. With forwarding, only a load whose result is needed by the instruction right behind it causes a wait, of one cycle. Two saturating counters report the instructions that have retired from writeback and the cycles that were lost to stalls. Together these give the cycle cost of every instruction: fetch-to-writeback cycles, minus the number of stages, plus one.

Top module: `hz_stall_ctrl`

## Requirements
- R1: `pc_en` and `ifid_en` are both low in a cycle where a stall is required and both high otherwise.
- R2: `idex_bubble` is high exactly in the stall cycles; the bubble it inserts enters execute as a non-instruction that never matches a source and never retires.
- R3: With FORWARD=0, decode stalls while a matching producer is in execute or memory, but not when the producer is in writeback; a consumer directly behind its producer stalls 2 cycles, and one with a single gap stalls 1 cycle.
- R4: With FORWARD=1, decode stalls only when the instruction in execute is a load whose destination matches a used source, for exactly 1 cycle; matches on non-load producers never stall.
- R5: A match counts only if the producer writes a register (`id_reg_write` was 1), its destination is not register 0, and the matching source is flagged as used.
- R6: A held instruction is issued once, after the stall ends; it is neither lost nor duplicated, so every valid decode instruction retires exactly once.
- R7: `retired_cnt` goes up by one for each valid instruction leaving writeback; the increment is visible 4 cycles after the cycle in which the instruction left decode. Bubbles do not count.
- R8: `stall_cnt` goes up by one for each stall cycle, visible in the next cycle.
- R9: Both counters are CNT_W bits wide and hold at all-ones instead of wrapping.
- R10: A clock edge with `rst_n` low clears all in-flight valid bits and both counters; after reset, with no valid decode instruction, both enables are high and `idex_bubble` is low.
- R11: A decode slot with `id_valid` low never causes a stall, whatever its register fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | 5 | First source register index |
| id_rs1_used | input | 1 | First source is read by the instruction |
| id_rs2 | input | 5 | Second source register index |
| id_rs2_used | input | 1 | Second source is read by the instruction |
| id_rd | input | 5 | Destination register index |
| id_reg_write | input | 1 | Instruction writes its destination register |
| id_is_load | input | 1 | Instruction is a memory load |
| pc_en | output | 1 | Program counter update enable |
| ifid_en | output | 1 | Fetch/decode register load enable |
| idex_bubble | output | 1 | Load a no-op bundle into decode/execute |
| retired_cnt | output | CNT_W | Saturating count of retired instructions |
| stall_cnt | output | CNT_W | Saturating count of stall cycles |

## Verification
The hardest case to reach from the ports is a producer that is exactly two slots ahead of its consumer. The stall must then last one cycle rather than two, and it ends just as the producer enters writeback. The bench reaches this case by placing an invalid slot between producer and consumer in its instruction stream. It also runs a long stream drawn from only four register numbers, so that back-to-back, gapped and chained dependences happen often. The stream also contains producers that write register 0, producers that do not write, and consumers that do not use their sources. A behavioural model tracks when each register becomes readable, and a second instance with narrow counters is driven until both counts reach their ceiling.

// File: rtl/hz_pkg.sv
// Shared types for the hazard stall controller.
// Assumes a 32-entry register file in which index 0 reads as a constant.
package hz_pkg;
    localparam int REG_AW = 5;

    typedef logic [REG_AW-1:0] reg_idx_t;

    // Per-stage record of an instruction in flight, as seen by hazard logic.
    typedef struct packed {
        logic     valid;
        reg_idx_t rd;
        logic     wr;
        logic     load;
    } stage_t;

    // True when stage s will write the register that source rs reads.
    function automatic logic src_hit(input stage_t s, input reg_idx_t rs,
                                     input logic used);
        return s.valid && s.wr && (s.rd != '0) && used && (s.rd == rs);
    endfunction
endpackage

// File: rtl/hz_track.sv
// Shadow of the pipeline behind decode: execute and memory records plus the
// writeback valid bit. A bubble request loads an empty record into execute.
// Assumes the real pipeline registers past decode never stall.
module hz_track
    import hz_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bubble,
    input  stage_t id_stage,
    output stage_t ex_q,
    output stage_t mem_q,
    output logic   wb_valid_q
);
    // Advance every record one stage per clock; reset empties the pipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q       <= '0;
            mem_q      <= '0;
            wb_valid_q <= 1'b0;
        end else begin
            ex_q       <= bubble ? '0 : id_stage;
            mem_q      <= ex_q;
            wb_valid_q <= mem_q.valid;
        end
    end

    AST_BUBBLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bubble) |-> !ex_q.valid); // R2
endmodule

// File: rtl/hz_detect.sv
// Combinational hazard check of the decode sources against older stages.
// FORWARD=0: any writer in execute or memory blocks (writeback is written
// before the register file is read). FORWARD=1: only a load in execute blocks.
module hz_detect
    import hz_pkg::*;
#(
    parameter bit FORWARD = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     id_valid,
    input  reg_idx_t id_rs1,
    input  logic     id_rs1_used,
    input  reg_idx_t id_rs2,
    input  logic     id_rs2_used,
    input  stage_t   ex_q,
    input  stage_t   mem_q,
    output logic     stall
);
    localparam int NCHK = 2;

    stage_t     chk [NCHK];
    logic [NCHK-1:0] hit;

    assign chk[0] = ex_q;
    assign chk[1] = mem_q;

    // One comparator pair per older stage; the policy masks stages and kinds.
    for (genvar i = 0; i < NCHK; i++) begin : g_stage
        localparam bit STAGE_ON = FORWARD ? (i == 0) : 1'b1;
        always_comb begin
            hit[i] = STAGE_ON
                  && (!FORWARD || chk[i].load)
                  && (src_hit(chk[i], id_rs1, id_rs1_used)
                   || src_hit(chk[i], id_rs2, id_rs2_used));
        end
    end

    assign stall = id_valid && (hit != '0);

    AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !stall); // R11

    if (FORWARD) begin : g_fwd_chk
        AST_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            stall |-> (ex_q.valid && ex_q.load)); // R4
    end else begin : g_nofwd_chk
        AST_PRODUCER_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
            stall |-> (ex_q.valid || mem_q.valid)); // R3
    end
endmodule

// File: rtl/hz_counter.sv
// Saturating event counter with synchronous active-low clear.
// Assumes at most one event per clock.
module hz_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Count events and stop at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && cnt != TOP)
            cnt <= cnt + 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt) == TOP |-> cnt == TOP); // R9
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)); // R7
endmodule

// File: rtl/hz_stall_ctrl.sv
// Hazard detection and stall control for a five-stage in-order pipeline.
// Freezes PC and fetch/decode and requests a decode/execute bubble when the
// decode instruction needs a value that cannot yet be supplied. Counts
// retired instructions and stall cycles.
// Assumes the decode fields are valid early in the cycle and that all
// enables and the bubble take effect at the next rising edge.
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter bit FORWARD = 1'b0,
    parameter int CNT_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 id_valid,
    input  logic [REG_AW-1:0]    id_rs1,
    input  logic                 id_rs1_used,
    input  logic [REG_AW-1:0]    id_rs2,
    input  logic                 id_rs2_used,
    input  logic [REG_AW-1:0]    id_rd,
    input  logic                 id_reg_write,
    input  logic                 id_is_load,
    output logic                 pc_en,
    output logic                 ifid_en,
    output logic                 idex_bubble,
    output logic [CNT_W-1:0]     retired_cnt,
    output logic [CNT_W-1:0]     stall_cnt
);
    stage_t id_stage;
    stage_t ex_q;
    stage_t mem_q;
    logic   wb_valid_q;
    logic   stall;

    // Pack the decode fields into the record that enters execute.
    always_comb begin
        id_stage.valid = id_valid;
        id_stage.rd    = id_rd;
        id_stage.wr    = id_reg_write;
        id_stage.load  = id_is_load;
    end

    hz_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .bubble     (stall),
        .id_stage   (id_stage),
        .ex_q       (ex_q),
        .mem_q      (mem_q),
        .wb_valid_q (wb_valid_q)
    );

    hz_detect #(.FORWARD(FORWARD)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_valid    (id_valid),
        .id_rs1      (id_rs1),
        .id_rs1_used (id_rs1_used),
        .id_rs2      (id_rs2),
        .id_rs2_used (id_rs2_used),
        .ex_q        (ex_q),
        .mem_q       (mem_q),
        .stall       (stall)
    );

    hz_counter #(.W(CNT_W)) u_retired (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wb_valid_q),
        .cnt   (retired_cnt)
    );

    hz_counter #(.W(CNT_W)) u_stalls (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (stall),
        .cnt   (stall_cnt)
    );

    assign pc_en       = !stall;
    assign ifid_en     = !stall;
    assign idex_bubble = stall;

    AST_FREEZE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |-> (!pc_en && !ifid_en)); // R1
    AST_STALL_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(idex_bubble) && $past(stall_cnt) != {CNT_W{1'b1}})
        |-> stall_cnt != $past(stall_cnt)); // R8
endmodule

// File: tb/test_hz_stall_ctrl.sv
// Drives two controllers (no forwarding with narrow counters, forwarding with
// full counters) from instruction streams and compares each cycle against a
// register-readiness model.
module test_hz_stall_ctrl;
    localparam int SAT_W = 4;
    localparam int MAXP  = 80;

    logic clk = 1'b0;
    always #10 clk = ~clk;
    logic rst_n;

    logic       dv   [2];
    logic [4:0] drs1 [2];
    logic       du1  [2];
    logic [4:0] drs2 [2];
    logic       du2  [2];
    logic [4:0] drd  [2];
    logic       dwr  [2];
    logic       dld  [2];
    logic       pe   [2];
    logic       fe   [2];
    logic       bub  [2];
    logic [SAT_W-1:0] ret0, stc0;
    logic [31:0]      ret1, stc1;

    hz_stall_ctrl #(.FORWARD(1'b0), .CNT_W(SAT_W)) i_hz_stall_ctrl (
        .clk(clk), .rst_n(rst_n), .id_valid(dv[0]), .id_rs1(drs1[0]),
        .id_rs1_used(du1[0]), .id_rs2(drs2[0]), .id_rs2_used(du2[0]),
        .id_rd(drd[0]), .id_reg_write(dwr[0]), .id_is_load(dld[0]),
        .pc_en(pe[0]), .ifid_en(fe[0]), .idex_bubble(bub[0]),
        .retired_cnt(ret0), .stall_cnt(stc0));

    hz_stall_ctrl #(.FORWARD(1'b1), .CNT_W(32)) i_hz_stall_ctrl_fwd (
        .clk(clk), .rst_n(rst_n), .id_valid(dv[1]), .id_rs1(drs1[1]),
        .id_rs1_used(du1[1]), .id_rs2(drs2[1]), .id_rs2_used(du2[1]),
        .id_rd(drd[1]), .id_reg_write(dwr[1]), .id_is_load(dld[1]),
        .pc_en(pe[1]), .ifid_en(fe[1]), .idex_bubble(bub[1]),
        .retired_cnt(ret1), .stall_cnt(stc1));

    int checks = 0;
    int errors = 0;

    int p_v [2][MAXP], p_a [2][MAXP], p_ua [2][MAXP], p_b [2][MAXP];
    int p_ub[2][MAXP], p_d [2][MAXP], p_w  [2][MAXP], p_l [2][MAXP];
    int p_len [2];
    int ready [2][32];
    int retire_at [2][MAXP];
    int rq_head [2], rq_tail [2];
    int st [2], rt [2], pc [2];

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put(input int k, input int v, input int a, input int ua,
                       input int b, input int ub, input int d, input int w,
                       input int l);
        int i;
        i = p_len[k];
        p_v[k][i] = v;  p_a[k][i] = a;  p_ua[k][i] = ua; p_b[k][i] = b;
        p_ub[k][i] = ub; p_d[k][i] = d; p_w[k][i] = w;   p_l[k][i] = l;
        p_len[k] = i + 1;
    endtask

    task automatic drive(input int k);
        int i;
        i = pc[k];
        if (i < p_len[k]) begin
            dv[k] = p_v[k][i] != 0;     drs1[k] = 5'(p_a[k][i]);
            du1[k] = p_ua[k][i] != 0;   drs2[k] = 5'(p_b[k][i]);
            du2[k] = p_ub[k][i] != 0;   drd[k]  = 5'(p_d[k][i]);
            dwr[k] = p_w[k][i] != 0;    dld[k]  = p_l[k][i] != 0;
        end else begin
            dv[k] = 1'b0; drs1[k] = '0; du1[k] = 1'b0; drs2[k] = '0;
            du2[k] = 1'b0; drd[k] = '0; dwr[k] = 1'b0; dld[k] = 1'b0;
        end
    endtask

    // Compare one instance in cycle m, then advance the model as the next edge will.
    task automatic step(input int k, input int m);
        bit      exp_stall;
        longint  cap, a_ret, a_st;
        int      i;
        string   tg;
        i = pc[k];
        exp_stall = 0;
        if (i < p_len[k] && p_v[k][i] != 0)
            exp_stall = (p_ua[k][i] != 0 && ready[k][p_a[k][i]] > m)
                     || (p_ub[k][i] != 0 && ready[k][p_b[k][i]] > m);
        while (rq_head[k] < rq_tail[k] && retire_at[k][rq_head[k]] <= m) begin
            rt[k]++;
            rq_head[k]++;
        end
        cap   = (k == 0) ? ((64'd1 << SAT_W) - 1) : 64'hFFFF_FFFF;
        a_ret = (k == 0) ? longint'(ret0) : longint'(ret1);
        a_st  = (k == 0) ? longint'(stc0) : longint'(stc1);
        if (i < p_len[k] && p_v[k][i] == 0) tg = "R11";
        else tg = (k == 0) ? "R3,R5" : "R4,R5";
        chk(tg, longint'(bub[k]), longint'(exp_stall));
        chk("R1 pc_en", longint'(pe[k]), longint'(!exp_stall));
        chk("R1 ifid_en", longint'(fe[k]), longint'(!exp_stall));
        chk("R2 bubble/freeze", longint'(bub[k]), longint'(!pe[k]));
        chk((rt[k] > cap) ? "R9 retired" : "R6,R7 retired", a_ret,
            (rt[k] > cap) ? cap : longint'(rt[k]));
        chk((st[k] > cap) ? "R9 stalls" : "R8 stalls", a_st,
            (st[k] > cap) ? cap : longint'(st[k]));
        if (exp_stall) begin
            st[k]++;
        end else begin
            if (i < p_len[k] && p_v[k][i] != 0) begin
                if (p_w[k][i] != 0 && p_d[k][i] != 0)
                    ready[k][p_d[k][i]] = (k == 0) ? m + 3
                                        : ((p_l[k][i] != 0) ? m + 2 : m + 1);
                retire_at[k][rq_tail[k]] = m + 4;
                rq_tail[k]++;
            end
            if (i < p_len[k]) pc[k] = i + 1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        int drain;
        seed = 32'h1234_5678;
        for (int k = 0; k < 2; k++) begin
            p_len[k] = 0; st[k] = 0; rt[k] = 0; pc[k] = 0;
            rq_head[k] = 0; rq_tail[k] = 0;
            for (int r = 0; r < 32; r++) ready[k][r] = 0;
            drive(k);
        end
        // No forwarding (R3, R5, R11): back-to-back, chained, r0, no-write,
        // unused source, invalid slot, one-gap and two-gap producers.
        put(0, 1, 0,0, 0,0, 1,1,0);
        put(0, 1, 1,1, 2,1, 3,1,0);
        put(0, 1, 3,1, 0,0, 4,1,0);
        put(0, 1, 0,0, 0,0, 0,1,0);
        put(0, 1, 0,1, 0,1, 2,0,0);
        put(0, 1, 2,1, 0,0, 1,1,0);
        put(0, 1, 1,0, 1,0, 7,1,0);
        put(0, 0, 7,1, 7,1, 0,0,0);
        put(0, 1, 0,0, 0,0, 8,1,0);
        put(0, 0, 0,0, 0,0, 0,0,0);
        put(0, 1, 8,1, 0,0, 9,1,0);
        put(0, 0, 0,0, 0,0, 0,0,0);
        put(0, 0, 0,0, 0,0, 0,0,0);
        put(0, 1, 0,0, 9,1, 10,1,0);
        // Forwarding (R4, R5): load-use, ALU-use, load with gap, load r0.
        put(1, 1, 0,0, 0,0, 5,1,1);
        put(1, 1, 5,1, 0,0, 6,1,0);
        put(1, 1, 6,1, 6,1, 7,1,1);
        put(1, 1, 0,0, 0,0, 8,1,0);
        put(1, 1, 7,1, 0,0, 0,1,1);
        put(1, 1, 0,1, 0,0, 9,1,1);
        put(1, 0, 0,0, 0,0, 0,0,0);
        put(1, 1, 0,0, 9,1, 10,1,0);
        // Dense random streams over four registers.
        for (int k = 0; k < 2; k++) begin
            for (int n = 0; n < 50; n++) begin
                int r;
                seed = seed * 1103515245 + 12345;
                r = (seed >>> 8) & 32'h00FF_FFFF;
                put(k, (r % 8) != 0, (r >> 3) % 4, (r >> 5) & 1, (r >> 6) % 4,
                    (r >> 8) & 1, (r >> 9) % 4, ((r >> 11) % 4) != 0,
                    (r >> 13) & 1);
            end
        end
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        // R10: cleared counters and open enables with an empty decode slot.
        chk("R10 retired", longint'(ret0), 0);
        chk("R10 stalls", longint'(stc1), 0);
        chk("R10 pc_en", longint'(pe[0]), 1);
        chk("R10 bubble", longint'(bub[1]), 0);
        rst_n = 1'b1;
        drain = 0;
        for (int m = 0; m < 2000 && drain < 8; m++) begin
            @(posedge clk);
            #1;
            drive(0);
            drive(1);
            @(negedge clk);
            step(0, m);
            step(1, m);
            if (pc[0] >= p_len[0] && pc[1] >= p_len[1]) drain++;
        end
        // R6: every valid instruction retired once; R9: narrow counter saturated.
        chk("R6 all retired", longint'(ret1), longint'(rq_tail[1]));
        chk("R9 narrow retired at ceiling", longint'(ret0), (1 << SAT_W) - 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule